// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the stream of column addresses that an SDRAM controller places on the bus, one per clock. A request carries a 9-bit start column, a 3-bit length code and an ordering bit. It is captured on a start strobe. From the next clock onward the block presents one column per cycle with a valid flag, and it flags the final beat of every fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the start column. The low bits either count upward and wrap (linear order) or are XORed with the beat index (interleaved order), and the upper column bits never change. A full-page burst walks the whole 512-column row, wrapping from 511 to 0, and runs until a terminate input stops it. A new strobe during a burst abandons the old burst at once.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and right after it, `valid_o`, `last_o` and `err_o` are 0.
- R2: When `start_i` is sampled high at a clock edge, the outputs after that same edge show `valid_o`=1 and `col_o` equal to the sampled `start_col_i`. In the cycle in which `start_i` is high, an idle block keeps `valid_o` low.
- R3: `bl_code_i` gives the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. Any code from 4 to 7 gives a full-page burst. A fixed burst shows exactly that many valid beats, and then `valid_o` drops.
- R4: With `ilv_i`=0, beat k of a fixed burst of length L carries the start column's bits above log2(L) unchanged. Its low log2(L) bits equal (start low bits + k) mod L.
- R5: With `ilv_i`=1, the low log2(L) bits of beat k equal the start low bits XOR k. For L=2 this gives the same order as `ilv_i`=0.
- R6: In a full-page burst, beat k is (start + k) mod 512. The beat shown in a cycle where `term_i` is high is the last one, and `valid_o` is 0 on the next cycle.
- R7: `term_i` has no effect on a fixed-length burst.
- R8: `last_o` is 1 exactly on the final beat of a fixed-length burst and is never 1 during a full-page burst.
- R9: A request with `ilv_i`=1 and a full-page code runs as a linear full-page burst. `err_o` is 1 for one cycle, together with its first beat.
- R10: A strobe during an active burst ends that burst. The old burst's beat is shown in the strobe cycle, and the new burst's first column follows on the next clock.
- R11: A 1-beat burst shows exactly one beat, equal to the start column, with `last_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request strobe |
| start_col_i | input | 9 | Start column, sampled with the strobe |
| bl_code_i | input | 3 | Burst length code, sampled with the strobe |
| ilv_i | input | 1 | 0 linear order, 1 interleaved order |
| term_i | input | 1 | Ends a running full-page burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | `col_o` carries a beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Interleaved full-page request was downgraded |

## Verification
The assertions assume that every input is driven to a known value on every clock edge. Request fields are taken to matter only in a cycle where `start_i` is high, and `term_i` is taken to matter only while a full-page burst shows a beat. The bench changes inputs only on the falling clock edge and holds the request fields steady while the strobe is high. It exercises `term_i` both in full-page bursts and in fixed bursts, where it should be ignored. One full-page request uses an out-of-range code (6) and one uses interleaved order, so that both downgrade paths are covered.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;
  localparam int unsigned COL_W     = 9;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned MAX_LOG_L = 3;

  typedef enum logic [CODE_W-1:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_PAGE = 3'd4
  } len_code_e;
endpackage

// File: rtl/colgen_len_dec.sv
module colgen_len_dec #(
  parameter int unsigned COL_W     = sdram_colgen_pkg::COL_W,
  parameter int unsigned CODE_W    = sdram_colgen_pkg::CODE_W,
  parameter int unsigned MAX_LOG_L = sdram_colgen_pkg::MAX_LOG_L
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [COL_W-1:0]  mask_o,
  output logic              full_o
);
  assign full_o = (int'(code_i) > int'(MAX_LOG_L));

  // bit b of the wrap mask is set when the burst spans 2^(b+1) columns or more
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign mask_o[b] = full_o | (int'(code_i) > b);
  end
endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl #(
  parameter int unsigned COL_W = sdram_colgen_pkg::COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  input  logic             term_i,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o,
  output logic             active_o,
  output logic             last_o,
  output logic             err_o
);
  logic fixed_end;
  logic burst_done;

  assign fixed_end  = ~full_o & (beat_o == mask_o);
  assign burst_done = full_o ? term_i : fixed_end;
  assign last_o     = active_o & fixed_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      base_o   <= '0;
      beat_o   <= '0;
      mask_o   <= '0;
      full_o   <= 1'b0;
      ilv_o    <= 1'b0;
      err_o    <= 1'b0;
    end else if (start_i) begin
      active_o <= 1'b1;
      base_o   <= start_col_i;
      beat_o   <= '0;
      mask_o   <= mask_i;
      full_o   <= full_i;
      ilv_o    <= ilv_i & ~full_i;
      err_o    <= ilv_i & full_i;
    end else begin
      err_o <= 1'b0;
      if (active_o) begin
        if (burst_done) active_o <= 1'b0;
        else            beat_o   <= beat_o + 1'b1;
      end
    end
  end

  p_beat_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !full_o) |-> ((beat_o & ~mask_o) == '0));

  p_fixed_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !full_o && !fixed_end && !start_i) |=> (active_o && beat_o == $past(beat_o) + 1'b1));

  p_err_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> !err_o);
endmodule

// File: rtl/colgen_addr_form.sv
module colgen_addr_form #(
  parameter int unsigned COL_W = sdram_colgen_pkg::COL_W
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] lin_sum;

  // carries only move upward, so masked low bits of the sum wrap inside the block
  assign lin_sum = base_i + beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = !mask_i[b] ? base_i[b] :
                      ilv_i      ? (base_i[b] ^ beat_i[b]) : lin_sum[b];
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int unsigned COL_W     = sdram_colgen_pkg::COL_W,
  parameter int unsigned CODE_W    = sdram_colgen_pkg::CODE_W,
  parameter int unsigned MAX_LOG_L = sdram_colgen_pkg::MAX_LOG_L
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] bl_code_i,
  input  logic              ilv_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              err_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             full_q, ilv_q;

  colgen_len_dec #(.COL_W(COL_W), .CODE_W(CODE_W), .MAX_LOG_L(MAX_LOG_L)) u_dec (
    .code_i (bl_code_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  colgen_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .full_i      (dec_full),
    .ilv_i       (ilv_i),
    .term_i      (term_i),
    .base_o      (base_q),
    .beat_o      (beat_q),
    .mask_o      (mask_q),
    .full_o      (full_q),
    .ilv_o       (ilv_q),
    .active_o    (valid_o),
    .last_o      (last_o),
    .err_o       (err_o)
  );

  colgen_addr_form #(.COL_W(COL_W)) u_addr (
    .base_i (base_q),
    .beat_i (beat_q),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );

  p_first_col_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  p_upper_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !full_q && !start_i) |=> ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));

  p_page_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && full_q && !term_i && !start_i) |=> (valid_o && col_o == $past(col_o) + 1'b1));

  p_term_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && full_q && term_i && !start_i) |=> !valid_o);

  p_last_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  p_no_page_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && full_q) |-> !last_o);
endmodule

// File: tb/sim_sdram_burst_colgen.sv
`timescale 1ns/1ps
module sim_sdram_burst_colgen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       term_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o, err_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [8:0] q_col[$];
  logic       q_last[$];
  logic       q_err[$];
  string      q_tag[$];

  always #10 clk_i = ~clk_i;

  sdram_burst_colgen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .ilv_i(ilv_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  function automatic logic [8:0] exp_col(logic [8:0] base, int code, bit ilv, int k);
    logic [8:0] m, kk;
    kk = 9'(k);
    if (code > 3) return base + kk;
    m = 9'((1 << code) - 1);
    if (ilv) return (base & ~m) | ((base ^ kk) & m);
    return (base & ~m) | ((base + kk) & m);
  endfunction

  task automatic push(logic [8:0] c, logic l, logic e, string tag);
    q_col.push_back(c); q_last.push_back(l); q_err.push_back(e); q_tag.push_back(tag);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drives one strobe; returns at the falling edge where beat 0 is shown
  task automatic strobe(logic [8:0] col, int code, bit ilv);
    start_col_i = col; bl_code_i = 3'(code); ilv_i = ilv; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic fixed_burst(logic [8:0] col, int code, bit ilv, bit term_hold, string tag);
    int n = 1 << code;
    for (int k = 0; k < n; k++) push(exp_col(col, code, ilv, k), k == n - 1, 1'b0, tag);
    term_i = term_hold;
    strobe(col, code, ilv);
    repeat (n - 1) @(negedge clk_i);
    term_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic page_burst(logic [8:0] col, int code, bit ilv, int n, string tag);
    for (int k = 0; k < n; k++) push(exp_col(col, 4, 1'b0, k), 1'b0, (k == 0) && ilv, tag);
    strobe(col, code, ilv);
    repeat (n - 1) @(negedge clk_i);
    term_i = 1'b1;
    @(negedge clk_i);
    term_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  // monitor: compares each shown beat with the head of the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (q_col.size() == 0) begin
        chk(1'b0, "R3 unexpected beat", int'(col_o), -1);
      end else begin
        logic [8:0] c; logic l, e; string t;
        c = q_col.pop_front(); l = q_last.pop_front(); e = q_err.pop_front(); t = q_tag.pop_front();
        chk(col_o == c, {t, " col"}, int'(col_o), int'(c));
        chk(last_o == l, {t, " last R8"}, int'(last_o), int'(l));
        chk(err_o == e, {t, " err R9"}, int'(err_o), int'(e));
      end
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
          n_run++; n_fail++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk_i);
    chk(!valid_o && !last_o && !err_o, "R1 in reset", int'({valid_o, last_o, err_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!valid_o && !last_o && !err_o, "R1 after reset", int'({valid_o, last_o, err_o}), 0);

    // R2: idle block keeps valid low during the strobe cycle
    start_col_i = 9'h0A3; bl_code_i = 3'd0; ilv_i = 1'b0; start_i = 1'b1;
    #1 chk(!valid_o, "R2 strobe cycle valid", int'(valid_o), 0);
    push(9'h0A3, 1'b1, 1'b0, "R11 single beat");
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (2) @(negedge clk_i);

    // R4 linear, length 8 from low bits 5: 5,6,7,0,1,2,3,4
    begin
      int ord[8] = '{5, 6, 7, 0, 1, 2, 3, 4};
      for (int k = 0; k < 8; k++) push(9'h1A8 | 9'(ord[k]), k == 7, 1'b0, "R4 linear L8");
      strobe(9'h1AD, 3, 1'b0);
      repeat (9) @(negedge clk_i);
    end
    // R5 interleaved, length 8 from 3: 3,2,1,0,7,6,5,4
    begin
      int ord[8] = '{3, 2, 1, 0, 7, 6, 5, 4};
      for (int k = 0; k < 8; k++) push(9'h050 | 9'(ord[k]), k == 7, 1'b0, "R5 interleave L8");
      strobe(9'h053, 3, 1'b1);
      repeat (9) @(negedge clk_i);
    end
    // R5 interleaved, length 4 from 1: 1,0,3,2
    begin
      int ord[4] = '{1, 0, 3, 2};
      for (int k = 0; k < 4; k++) push(9'h1F0 | 9'(ord[k]), k == 3, 1'b0, "R5 interleave L4");
      strobe(9'h1F1, 2, 1'b1);
      repeat (5) @(negedge clk_i);
    end
    fixed_burst(9'h0FF, 1, 1'b1, 1'b0, "R5 interleave L2");
    fixed_burst(9'h0FF, 1, 1'b0, 1'b0, "R3 linear L2");
    fixed_burst(9'h13E, 2, 1'b0, 1'b0, "R4 linear L4");
    fixed_burst(9'h006, 3, 1'b1, 1'b0, "R5 interleave L8b");
    fixed_burst(9'h10B, 0, 1'b0, 1'b0, "R11 single beat b");
    fixed_burst(9'h0C2, 2, 1'b0, 1'b1, "R7 term ignored L4");
    fixed_burst(9'h0C7, 3, 1'b1, 1'b1, "R7 term ignored L8");

    page_burst(9'd500, 4, 1'b0, 20, "R6 page wrap");
    page_burst(9'd77, 4, 1'b0, 1, "R6 page one beat");
    page_burst(9'd300, 6, 1'b0, 3, "R3 page code 6");
    page_burst(9'd510, 4, 1'b1, 5, "R9 interleave page");

    // R10: abort an L8 burst after its fourth beat
    for (int k = 0; k < 4; k++) push(exp_col(9'h021, 3, 1'b0, k), 1'b0, 1'b0, "R10 aborted");
    strobe(9'h021, 3, 1'b0);
    repeat (3) @(negedge clk_i);
    for (int k = 0; k < 4; k++) push(exp_col(9'h1C6, 2, 1'b1, k), k == 3, 1'b0, "R10 new burst");
    strobe(9'h1C6, 2, 1'b1);
    repeat (5) @(negedge clk_i);

    chk(q_col.size() == 0, "R3 all beats delivered", q_col.size(), 0);
    chk(!valid_o, "R3 idle at end", int'(valid_o), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule